// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Sequencer

This block is the digital timing core of a 1/3-bias multiplexed LCD driver. It scans the active common electrodes in turn. Each common's time slot is split into a positive half and a negative half, so the panel sees no net DC voltage. For every panel pin it emits a 2-bit code that tells the analog level drivers which of four bias rails to connect: VSS, VL1, VL2 or VL3. The bias generator, charge pump and output stages sit outside this block.

The clock is the low-speed clock. A whole frame always lasts a fixed number of clocks chosen by a 2-bit rate field, so the frame rate does not depend on the duty. The CPU writes a small display RAM a byte at a time. It also writes one column pointer per pin, which decides which RAM bits a segment pin shows. Three of the pins act as commons or as segments, depending on the number of commons in use. Besides normal display, the block has a stop mode and two forced modes that light every segment or blank every segment.

Top module: `lcdmux_seq`

## Requirements
- R1: After reset all display RAM bits are 0, the column pointer of pin p equals p, and the scan is at common 0, positive half.
- R2: With mode code 0 (stop), every pin outputs code 0 (VSS) and the scan is held at common 0, positive half. A later run mode starts from that point.
- R3: Level codes are 0=VSS, 1=VL1, 2=VL2, 3=VL3. The selected common outputs 3 in the positive half and 0 in the negative half. Any other common outputs 1 in the positive half and 2 in the negative half.
- R4: An on segment outputs 0 in the positive half and 3 in the negative half. An off segment outputs 2 in the positive half and 1 in the negative half.
- R5: A duty code d of 0 to 4 selects n=d+1 commons. Codes 5 to 7 select 5 commons.
- R6: Pins 0 and 1 are always commons. Pins 2 to 4 are commons when their index is below n and segments otherwise. Pins 5 to 15 are always segments.
- R7: The frame lasts F=64*(8-fsel) clocks (512, 448, 384 or 320). Its 2n halves run in the order common 0 positive, common 0 negative, common 1 positive, and so on. After k running clocks the half index is floor(k*2n/F) mod 2n.
- R8: A write with wr_sel_i=0 stores wr_data_i into RAM bits 8a to 8a+7, where a is wr_addr_i. Addresses 22 and above change nothing.
- R9: A write with wr_sel_i=1 sets the 6-bit column pointer of pin wr_addr_i from wr_data_i[5:0]. Pin addresses 16 and above change nothing. In display mode, segment pin p at common c shows RAM bit col*5+c. An index of 176 or more reads as off.
- R10: Mode code 2 forces every segment on and mode code 3 forces every segment off. In both modes the commons keep scanning.
- R11: Mode code 1 (display) drives each segment from its allocated RAM bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 stop, 1 display, 2 all on, 3 all off |
| duty_i | input | 3 | Number of commons minus one |
| fsel_i | input | 2 | Frame length select |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 writes a RAM byte, 1 writes a column pointer |
| wr_addr_i | input | 5 | RAM byte address or pin index |
| wr_data_i | input | 8 | Write data |
| lvl_o | output | 32 | Level code of pin p on bits 2p+1:2p |

## Verification
The assertions assume that duty_i and fsel_i change only while the block is in stop mode. The checks on common range and on wrap-around take the common count as fixed while the scan runs. The bench changes duty and frame rate only inside a stop interval, and each of those intervals lasts at least one clock edge. Mode changes are applied between clock edges, and the bench moves straight from stop into a run mode.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;
  typedef enum logic [1:0] {
    LV_VSS = 2'd0,
    LV_VL1 = 2'd1,
    LV_VL2 = 2'd2,
    LV_VL3 = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    MD_STOP   = 2'd0,
    MD_SHOW   = 2'd1,
    MD_ALLON  = 2'd2,
    MD_ALLOFF = 2'd3
  } mode_e;
endpackage

// File: rtl/lcdmux_scan.sv
// Half-phase sequencer: a fractional accumulator spreads 2n halves over F clocks.
module lcdmux_scan #(
  parameter int NCOM_MAX   = 5,
  parameter int FRAME_UNIT = 64,
  localparam int CW = $clog2(NCOM_MAX),
  localparam int NW = $clog2(NCOM_MAX + 1),
  localparam int FW = $clog2(FRAME_UNIT * 8) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [NW-1:0] ncom_i,
  input  logic [1:0]    fsel_i,
  output logic [CW-1:0] com_o,
  output logic          ph_o
);
  logic [FW-1:0] acc_q, acc_d, flen, step, sum;
  logic [CW-1:0] com_q, com_d;
  logic          ph_q, ph_d;

  always_comb begin
    flen  = FW'(FRAME_UNIT * (8 - int'(fsel_i)));
    step  = FW'({ncom_i, 1'b0});
    sum   = acc_q + step;
    acc_d = acc_q;
    com_d = com_q;
    ph_d  = ph_q;
    if (!run_i) begin
      acc_d = '0;
      com_d = '0;
      ph_d  = 1'b0;
    end else if (sum >= flen) begin
      acc_d = sum - flen;
      if (!ph_q) begin
        ph_d = 1'b1;
      end else begin
        ph_d  = 1'b0;
        com_d = (int'(com_q) + 1 >= int'(ncom_i)) ? '0 : com_q + CW'(1);
      end
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      com_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      com_q <= com_d;
      ph_q  <= ph_d;
    end
  end

  assign com_o = com_q;
  assign ph_o  = ph_q;
endmodule

// File: rtl/lcdmux_store.sv
// Display RAM and per-pin column pointers, with one read port per pin.
module lcdmux_store #(
  parameter int NPIN     = 16,
  parameter int RAM_BITS = 176,
  parameter int NCOM_MAX = 5,
  localparam int RAM_BYTES = RAM_BITS / 8,
  localparam int WAW  = $clog2((RAM_BYTES > NPIN) ? RAM_BYTES : NPIN),
  localparam int COLW = $clog2(RAM_BITS / NCOM_MAX),
  localparam int CW   = $clog2(NCOM_MAX),
  localparam int IDXW = COLW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [WAW-1:0]  wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [CW-1:0]   com_i,
  output logic [NPIN-1:0] seg_bit_o
);
  logic [RAM_BITS-1:0]    ram_q, ram_d;
  logic [COLW-1:0]        col_q [NPIN];
  logic [COLW-1:0]        col_d [NPIN];
  logic [(1<<IDXW)-1:0]   ram_ext;

  always_comb begin
    ram_d = ram_q;
    col_d = col_q;
    if (wr_en_i && !wr_sel_i) begin
      for (int b = 0; b < RAM_BYTES; b++) begin
        if (wr_addr_i == WAW'(b)) ram_d[b*8 +: 8] = wr_data_i;
      end
    end
    if (wr_en_i && wr_sel_i) begin
      for (int p = 0; p < NPIN; p++) begin
        if (wr_addr_i == WAW'(p)) col_d[p] = wr_data_i[COLW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_q <= '0;
      for (int p = 0; p < NPIN; p++) col_q[p] <= COLW'(p);
    end else begin
      ram_q <= ram_d;
      for (int p = 0; p < NPIN; p++) col_q[p] <= col_d[p];
    end
  end

  // Bits past the RAM read as zero, so an out-of-range pointer shows "off".
  assign ram_ext = {{((1<<IDXW)-RAM_BITS){1'b0}}, ram_q};

  for (genvar p = 0; p < NPIN; p++) begin : g_rd
    logic [IDXW-1:0] idx;
    assign idx          = IDXW'(col_q[p]) * IDXW'(NCOM_MAX) + IDXW'(com_i);
    assign seg_bit_o[p] = ram_ext[idx];
  end
endmodule

// File: rtl/lcdmux_pin.sv
// Maps role, polarity and hit onto one of four bias rails.
module lcdmux_pin
  import lcdmux_pkg::*;
(
  input  logic       run_i,
  input  logic       ph_i,
  input  logic       is_com_i,
  input  logic       hit_i,
  output logic [1:0] lvl_o
);
  lvl_e lv;

  always_comb begin
    if (!run_i)        lv = LV_VSS;
    else if (is_com_i) lv = ph_i ? (hit_i ? LV_VSS : LV_VL2) : (hit_i ? LV_VL3 : LV_VL1);
    else               lv = ph_i ? (hit_i ? LV_VL3 : LV_VL1) : (hit_i ? LV_VSS : LV_VL2);
  end

  assign lvl_o = lv;
endmodule

// File: rtl/lcdmux_seq.sv
module lcdmux_seq
  import lcdmux_pkg::*;
#(
  parameter int NPIN       = 16,
  parameter int NCOM_MAX   = 5,
  parameter int NCOM_DED   = 2,
  parameter int RAM_BITS   = 176,
  parameter int FRAME_UNIT = 64,
  localparam int NW  = $clog2(NCOM_MAX + 1),
  localparam int WAW = $clog2((RAM_BITS / 8 > NPIN) ? RAM_BITS / 8 : NPIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [NW-1:0]     duty_i,
  input  logic [1:0]        fsel_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WAW-1:0]    wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [2*NPIN-1:0] lvl_o
);
  localparam int CW = $clog2(NCOM_MAX);

  logic [1:0]      rs_q;
  logic            rst_int;
  logic            run_w, ph_w;
  logic [NW-1:0]   ncom_w;
  logic [CW-1:0]   com_w;
  logic [NPIN-1:0] seg_bit, seg_on, is_com, hit;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  assign run_w  = (mode_i != MD_STOP);
  assign ncom_w = (int'(duty_i) < NCOM_MAX) ? NW'(int'(duty_i) + 1) : NW'(NCOM_MAX);

  lcdmux_scan #(.NCOM_MAX(NCOM_MAX), .FRAME_UNIT(FRAME_UNIT)) u_scan (
    .clk(clk), .rst_n(rst_int), .run_i(run_w), .ncom_i(ncom_w),
    .fsel_i(fsel_i), .com_o(com_w), .ph_o(ph_w)
  );

  lcdmux_store #(.NPIN(NPIN), .RAM_BITS(RAM_BITS), .NCOM_MAX(NCOM_MAX)) u_store (
    .clk(clk), .rst_n(rst_int), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .com_i(com_w),
    .seg_bit_o(seg_bit)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign seg_on[p] = (mode_i == MD_ALLON) || ((mode_i == MD_SHOW) && seg_bit[p]);
    if (p < NCOM_DED) begin : g_com
      assign is_com[p] = 1'b1;
      assign hit[p]    = (int'(com_w) == p);
    end else if (p < NCOM_MAX) begin : g_shr
      assign is_com[p] = (int'(ncom_w) > p);
      assign hit[p]    = is_com[p] ? (int'(com_w) == p) : seg_on[p];
    end else begin : g_seg
      assign is_com[p] = 1'b0;
      assign hit[p]    = seg_on[p];
    end
    lcdmux_pin u_pin (
      .run_i(run_w), .ph_i(ph_w), .is_com_i(is_com[p]), .hit_i(hit[p]),
      .lvl_o(lvl_o[2*p +: 2])
    );
  end
endmodule

// File: rtl/lcdmux_seq_chk.sv
module lcdmux_seq_chk #(
  parameter int NPIN     = 16,
  parameter int NCOM_MAX = 5,
  parameter int NW       = 3,
  parameter int CW       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic [NW-1:0]     ncom_i,
  input logic [CW-1:0]     com_i,
  input logic              ph_i,
  input logic [2*NPIN-1:0] lvl_i
);
  logic [NCOM_MAX-1:0] top3;
  logic                run;

  always_comb begin
    for (int i = 0; i < NCOM_MAX; i++) top3[i] = (lvl_i[2*i +: 2] == 2'd3);
  end
  assign run = (mode_i != 2'd0);

  p_stop_vss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (lvl_i == '0));

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (com_i == '0 && !ph_i));

  p_com_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(com_i) < int'(ncom_i));

  p_pos_then_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_i) |-> $stable(com_i));

  p_next_com_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ph_i) && $past(run)) |->
      (com_i == ((int'($past(com_i)) + 1 >= int'(ncom_i)) ? '0 : $past(com_i) + CW'(1))));

  p_com0_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lvl_i[0] == !ph_i));

  p_seg_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (lvl_i[2*NPIN-2] == ph_i));

  p_one_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ph_i) |-> ($countones(top3) == 1));

  p_allon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && !ph_i) |-> (lvl_i[2*NPIN-1 -: 2] == 2'd0));
endmodule

bind lcdmux_seq lcdmux_seq_chk #(
  .NPIN(NPIN), .NCOM_MAX(NCOM_MAX), .NW(NW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ncom_i(ncom_w),
  .com_i(com_w), .ph_i(ph_w), .lvl_i(lvl_o)
);

// File: tb/sim_lcdmux_seq.sv
module sim_lcdmux_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [2:0]  duty;
  logic [1:0]  fsel;
  logic        wr_en, wr_sel;
  logic [4:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [31:0] lvl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit ram_m [176];
  int col_m [16];

  always #5 clk = ~clk;

  lcdmux_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .duty_i(duty), .fsel_i(fsel),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lvl_o(lvl)
  );

  function automatic logic [1:0] exp_pin(int p, int n, int c, int ph, int md);
    bit iscom, hit;
    int idx;
    if (md == 0) return 2'd0;
    iscom = (p < 2) || (p < 5 && p < n);
    if (iscom) begin
      hit = (p == c);
      return (ph == 0) ? (hit ? 2'd3 : 2'd1) : (hit ? 2'd0 : 2'd2);
    end
    if (md == 2)      hit = 1;
    else if (md == 3) hit = 0;
    else begin
      idx = col_m[p] * 5 + c;
      hit = (idx < 176) ? ram_m[idx] : 1'b0;
    end
    return (ph == 0) ? (hit ? 2'd0 : 2'd2) : (hit ? 2'd3 : 2'd1);
  endfunction

  function automatic logic [31:0] exp_vec(int n, int c, int ph, int md);
    logic [31:0] v;
    for (int p = 0; p < 16; p++) v[2*p +: 2] = exp_pin(p, n, c, ph, md);
    return v;
  endfunction

  task automatic check_vec(input logic [31:0] exp, input string tag);
    n_cmp++;
    if (lvl !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, lvl, exp);
    end
  endtask

  task automatic wr_ram(input int a, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 5'(a); wr_data = 8'(v);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 22) for (int b = 0; b < 8; b++) ram_m[a*8 + b] = v[b];
  endtask

  task automatic wr_col(input int p, input int c);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_addr = 5'(p); wr_data = 8'(c);
    @(negedge clk);
    wr_en = 1'b0;
    if (p < 16) col_m[p] = c % 64;
  endtask

  // Stop for one edge, then run nedges clocks (0 means a full frame plus 3).
  task automatic run_frame(input int d, input int fs, input int md, input int nedges,
                           input string tag);
    int n, f, s, last;
    n = (d < 5) ? d + 1 : 5;
    f = 64 * (8 - fs);
    last = (nedges == 0) ? f + 3 : nedges;
    @(negedge clk);
    mode = 2'd0; duty = 3'(d); fsel = 2'(fs);
    @(negedge clk);
    #1 check_vec('0, "R2 stop forces VSS");
    mode = 2'(md);
    #1 check_vec(exp_vec(n, 0, 0, md), {tag, " k=0"});
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      #1;
      s = ((k * 2 * n) / f) % (2 * n);
      check_vec(exp_vec(n, s / 2, s % 2, md), tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 176; i++) ram_m[i] = 1'b0;
    for (int p = 0; p < 16; p++) col_m[p] = p;
    rst_n = 1'b0; mode = 2'd0; duty = 3'd4; fsel = 2'd0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    #1 check_vec('0, "R1 reset outputs");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: cleared RAM and identity pointers give all segments off.
    run_frame(4, 0, 1, 40, "R1 cleared RAM");

    for (int a = 0; a < 22; a++) wr_ram(a, (a * 73 + 29) & 255);
    // R5 R6 R7 R11 R3 R4: every duty code, every frame length.
    for (int d = 0; d < 8; d++) run_frame(d, d % 4, 1, 0, "R3 R4 R5 R6 R7 R11 sweep");

    // R9: reprogrammed pointers, one of them out of range.
    for (int p = 0; p < 16; p++) wr_col(p, (p * 7 + 3) % 35);
    wr_col(15, 40);
    run_frame(4, 1, 1, 0, "R9 allocation d5");
    run_frame(1, 2, 1, 0, "R9 allocation d2");

    // R8 R9: writes past the address range change nothing.
    wr_ram(25, 255);
    wr_ram(30, 255);
    wr_col(20, 0);
    wr_col(31, 1);
    wr_ram(21, 0);
    run_frame(4, 3, 1, 0, "R8 R9 ignored writes");

    // R10: forced modes keep the commons scanning.
    run_frame(2, 0, 2, 0, "R10 all on");
    run_frame(2, 0, 3, 0, "R10 all off");

    // R2: stop part-way through a frame, then resume from the start.
    run_frame(3, 1, 1, 100, "R2 R7 partial");
    run_frame(3, 1, 1, 0, "R2 R7 resume");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule